// File: doc/BRIEF.md
# Strided DMA Address Generator

This block computes the address sequence for one side of a DMA transfer: either the read side or the write side. A start pulse captures four things: a base address, a 22-bit total byte count, a stride-enable bit and a 32-bit parameter word. The parameter word holds the beat size, the movement mode, a block size and a stride. The block then presents one beat at a time, giving the beat's address and its byte count. The data path takes a beat by raising its accept input.

The address can move up, move down, stay fixed, or move up with a burst marker on every beat. With stride enabled, the transfer is split into blocks. Once a block's worth of bytes has been issued, the next block starts at the previous block's start address offset by the stride. The beat that closes a block is flagged. The beat that uses up the byte count is flagged as final, and if fewer bytes remain than a full beat, that beat reports only the remaining bytes.

Top module: `stride_agen`

## Requirements
- R1: After reset, beat_valid, done, block_end and burst_flag are all low.
- R2: A start pulse loads all parameters and restarts the generator. From the next cycle, beat_valid is high and beat_addr equals base_addr. If byte_total is zero, beat_valid stays low.
- R3: Parameter bits 31:30 set the beat size: 0 gives 1 byte, 1 gives 2, 2 gives 4 and 3 gives 8. Every presented beat has beat_bytes between 1 and the beat size.
- R4: Movement code 0 in bits 29:28 (increment) adds the beat size to the address after each accepted beat.
- R5: Movement code 1 (decrement) subtracts the beat size after each accepted beat.
- R6: Movement code 2 (static) keeps the address fixed for the whole transfer.
- R7: Movement code 3 (burst) steps the address like increment and holds burst_flag high on every presented beat. In the other modes, burst_flag is low.
- R8: The address and the remaining count change only in cycles where beat_valid and beat_accept are both high. While accept is low, the beat is held unchanged.
- R9: done is high on the beat that uses up the byte count. That beat carries only the remaining bytes when they are fewer than the beat size. After that beat is accepted, beat_valid goes low.
- R10: With stride_en set, bits 27:14 give the block size and bits 13:0 give the stride, both in bytes. block_end is high on the beat that brings the bytes issued in the current block to at least the block size. The next beat starts at the block start plus the stride, or at the block start minus the stride in decrement mode.
- R11: With stride_en clear, or with a block size of zero, the block size and stride fields are ignored. The address moves linearly and block_end stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load parameters and begin a transfer |
| base_addr | input | AW | First beat address |
| param_word | input | 32 | Size, movement, block size and stride |
| byte_total | input | 22 | Total bytes to transfer |
| stride_en | input | 1 | Enable block/stride stepping |
| beat_accept | input | 1 | Data path takes the presented beat |
| beat_valid | output | 1 | A beat is presented |
| beat_addr | output | AW | Address of the presented beat |
| beat_bytes | output | 4 | Bytes in the presented beat |
| burst_flag | output | 1 | Beat belongs to a burst-mode transfer |
| block_end | output | 1 | Presented beat closes a stride block |
| done | output | 1 | Presented beat is the last one |

## Verification
The assertions assume that start is a single-cycle pulse and that beat_accept matters only while a beat is presented. A stall is treated as beat_accept low with no start. The directed tasks drive inputs on the falling edge. Each task raises start for exactly one cycle and holds accept for exactly one cycle per beat taken. A separate task holds accept low over several cycles to exercise stalls. Block sizes are chosen as multiples of the beat size, and the address sequences stay clear of wrap-around, so the expected values can be written down directly.

// File: rtl/stride_agen.sv
module stride_agen #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [31:0]   param_word,
  input  logic [21:0]   byte_total,
  input  logic          stride_en,
  input  logic          beat_accept,
  output logic          beat_valid,
  output logic [AW-1:0] beat_addr,
  output logic [3:0]    beat_bytes,
  output logic          burst_flag,
  output logic          block_end,
  output logic          done
);
  localparam int CW = 22;
  localparam int FW = 14;
  localparam logic [1:0] MV_INC   = 2'd0;
  localparam logic [1:0] MV_DEC   = 2'd1;
  localparam logic [1:0] MV_STAT  = 2'd2;
  localparam logic [1:0] MV_BURST = 2'd3;

  logic          busy;
  logic [AW-1:0] addr_q, blk_start_q;
  logic [CW-1:0] remain_q;
  logic [FW-1:0] blk_cnt_q, blk_size_q, stride_q;
  logic [1:0]    size_q, mode_q;
  logic          stride_on_q;

  logic [3:0]    full_bytes;
  logic [CW-1:0] full_ext;
  logic          fire;
  logic [FW:0]   blk_sum;
  logic [AW-1:0] step, stride_x, next_blk;

  assign full_bytes = 4'd1 << size_q;
  assign full_ext   = {{(CW-4){1'b0}}, full_bytes};
  assign beat_bytes = (remain_q < full_ext) ? remain_q[3:0] : full_bytes;
  assign done       = busy && (remain_q <= full_ext);
  assign fire       = busy && beat_accept;
  assign blk_sum    = {1'b0, blk_cnt_q} + {{(FW-3){1'b0}}, beat_bytes};
  assign block_end  = busy && stride_on_q && (blk_size_q != '0) && (mode_q != MV_STAT)
                      && (blk_sum >= {1'b0, blk_size_q});
  assign step       = {{(AW-4){1'b0}}, full_bytes};
  assign stride_x   = {{(AW-FW){1'b0}}, stride_q};
  assign next_blk   = (mode_q == MV_DEC) ? blk_start_q - stride_x : blk_start_q + stride_x;

  assign beat_valid = busy;
  assign beat_addr  = addr_q;
  assign burst_flag = busy && (mode_q == MV_BURST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      addr_q      <= '0;
      blk_start_q <= '0;
      remain_q    <= '0;
      blk_cnt_q   <= '0;
      blk_size_q  <= '0;
      stride_q    <= '0;
      size_q      <= '0;
      mode_q      <= MV_INC;
      stride_on_q <= 1'b0;
    end else if (start) begin
      busy        <= (byte_total != '0);
      addr_q      <= base_addr;
      blk_start_q <= base_addr;
      remain_q    <= byte_total;
      blk_cnt_q   <= '0;
      size_q      <= param_word[31:30];
      mode_q      <= param_word[29:28];
      blk_size_q  <= param_word[27:14];
      stride_q    <= param_word[13:0];
      stride_on_q <= stride_en;
    end else if (fire) begin
      remain_q <= remain_q - {{(CW-4){1'b0}}, beat_bytes};
      if (done) busy <= 1'b0;
      if (mode_q != MV_STAT) begin
        if (block_end) begin
          addr_q      <= next_blk;
          blk_start_q <= next_blk;
          blk_cnt_q   <= '0;
        end else begin
          addr_q    <= (mode_q == MV_DEC) ? addr_q - step : addr_q + step;
          blk_cnt_q <= blk_sum[FW-1:0];
        end
      end
    end
  end

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_accept && !start |=> beat_valid && $stable(beat_addr) && $stable(beat_bytes)); // R8
  AST_BYTES_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (beat_bytes != 4'd0) && (beat_bytes <= 4'd8)); // R3
  AST_STATIC_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_accept && !done && !start && (mode_q == MV_STAT) |=> beat_addr == $past(beat_addr)); // R6
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_accept && done && !start |=> !beat_valid); // R9
  AST_BLOCKEND_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    block_end |-> beat_valid && stride_on_q); // R11
  AST_BURST_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    burst_flag |-> beat_valid); // R7
endmodule

// File: tb/sim_stride_agen.sv
module sim_stride_agen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [31:0] param_word = '0;
  logic [21:0] byte_total = '0;
  logic        stride_en = 1'b0;
  logic        beat_accept = 1'b0;
  logic        beat_valid, burst_flag, block_end, done;
  logic [31:0] beat_addr;
  logic [3:0]  beat_bytes;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  stride_agen #(.AW(32)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .param_word(param_word), .byte_total(byte_total), .stride_en(stride_en),
    .beat_accept(beat_accept), .beat_valid(beat_valid), .beat_addr(beat_addr),
    .beat_bytes(beat_bytes), .burst_flag(burst_flag), .block_end(block_end), .done(done));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pw(int sz, int mv, int blk, int str);
    return {sz[1:0], mv[1:0], blk[13:0], str[13:0]};
  endfunction

  task automatic kick(logic [31:0] b, logic [31:0] p, int n, logic se);
    @(negedge clk);
    base_addr = b; param_word = p; byte_total = n[21:0]; stride_en = se; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic take(string req, logic [31:0] a, int nb, logic dn, logic be, logic bu);
    beat_accept = 1'b1;
    #1;
    chk({req, " valid"}, beat_valid, 1);
    chk({req, " addr"}, beat_addr, a);
    chk({req, " bytes"}, beat_bytes, nb);
    chk({req, " done"}, done, dn);
    chk({req, " block_end"}, block_end, be);
    chk({req, " burst"}, burst_flag, bu);
    @(negedge clk);
    beat_accept = 1'b0;
  endtask

  task automatic idle_after(string req);
    #1;
    chk({req, " valid low after last"}, beat_valid, 0);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 valid", beat_valid, 0);
    chk("R1 done", done, 0);
    chk("R1 block_end", block_end, 0);
    chk("R1 burst", burst_flag, 0);
  endtask

  task automatic t_increment;
    kick(32'h1000, pw(2, 0, 0, 0), 10, 1'b0);
    take("R2 R3 R4", 32'h1000, 4, 0, 0, 0);
    take("R4", 32'h1004, 4, 0, 0, 0);
    take("R9 short tail", 32'h1008, 2, 1, 0, 0);
    idle_after("R9");
  endtask

  task automatic t_decrement;
    kick(32'h200, pw(1, 1, 0, 0), 4, 1'b0);
    take("R5", 32'h200, 2, 0, 0, 0);
    take("R5", 32'h1FE, 2, 1, 0, 0);
    idle_after("R5");
  endtask

  task automatic t_static;
    kick(32'h3000, pw(3, 2, 0, 0), 16, 1'b0);
    take("R6", 32'h3000, 8, 0, 0, 0);
    take("R6", 32'h3000, 8, 1, 0, 0);
    idle_after("R6");
  endtask

  task automatic t_burst;
    kick(32'h40, pw(0, 3, 0, 0), 3, 1'b0);
    take("R7", 32'h40, 1, 0, 0, 1);
    take("R7", 32'h41, 1, 0, 0, 1);
    take("R7", 32'h42, 1, 1, 0, 1);
    idle_after("R7");
  endtask

  task automatic t_stall;
    kick(32'h100, pw(2, 0, 0, 0), 8, 1'b0);
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R8 stalled valid", beat_valid, 1);
      chk("R8 stalled addr", beat_addr, 32'h100);
      chk("R8 stalled bytes", beat_bytes, 4);
      @(negedge clk);
    end
    take("R8", 32'h100, 4, 0, 0, 0);
    take("R8", 32'h104, 4, 1, 0, 0);
    idle_after("R8");
  endtask

  task automatic t_stride_inc;
    kick(32'h1000, pw(2, 0, 8, 32'h100), 24, 1'b1);
    take("R10", 32'h1000, 4, 0, 0, 0);
    take("R10", 32'h1004, 4, 0, 1, 0);
    take("R10", 32'h1100, 4, 0, 0, 0);
    take("R10", 32'h1104, 4, 0, 1, 0);
    take("R10", 32'h1200, 4, 0, 0, 0);
    take("R10", 32'h1204, 4, 1, 1, 0);
    idle_after("R10");
  endtask

  task automatic t_stride_dec;
    kick(32'h500, pw(2, 1, 4, 32'h10), 8, 1'b1);
    take("R10 dec", 32'h500, 4, 0, 1, 0);
    take("R10 dec", 32'h4F0, 4, 1, 1, 0);
    idle_after("R10 dec");
  endtask

  task automatic t_stride_off;
    kick(32'h800, pw(2, 0, 4, 32'h100), 12, 1'b0);
    take("R11", 32'h800, 4, 0, 0, 0);
    take("R11", 32'h804, 4, 0, 0, 0);
    take("R11", 32'h808, 4, 1, 0, 0);
    idle_after("R11");
    kick(32'h900, pw(2, 0, 0, 32'h100), 8, 1'b1);
    take("R11 zero block", 32'h900, 4, 0, 0, 0);
    take("R11 zero block", 32'h904, 4, 1, 0, 0);
  endtask

  task automatic t_zero_len;
    kick(32'hABC0, pw(2, 0, 0, 0), 0, 1'b0);
    #1;
    chk("R2 zero length valid", beat_valid, 0);
    @(negedge clk);
    #1;
    chk("R2 zero length stays idle", beat_valid, 0);
  endtask

  initial begin
    #100000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_increment();
    t_decrement();
    t_static();
    t_burst();
    t_stall();
    t_stride_inc();
    t_stride_dec();
    t_stride_off();
    t_zero_len();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule